// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a processor's instruction fetch port and a word-wide main-memory read port. The fetch side offers a byte address with a request/ready handshake. One clock after the request is taken, or later if memory must be read, it receives a 32-bit opcode with a one-cycle valid strobe. Fetches to the two cacheable RAM windows (top address byte 0x00 or 0x80) are looked up in a direct-mapped store of 1024 words. A miss brings in the whole aligned 16-byte line and then answers. Every other address is read straight from memory and leaves the store untouched.

Every word slot carries its own 24-bit tag, which is the low 24 bits of the word-aligned address that filled it. The same physical word seen through the 0x00 and the 0x80 windows therefore shares one entry. Both arrays start out all-ones, which marks every entry invalid. Reset and the flush input bring them back to that state by walking the arrays one entry per clock. While the walk runs, fetches are refused. Nothing in the block watches memory writes. After memory changes, old opcodes keep being returned until a flush.

Top module: `ifetch_cache`

## Requirements
- R1: After reset is released, fetch_ready stays low while the arrays are cleared one word per clock and rises after exactly WORDS (1024) rising edges. A flush pulse sampled while the port is idle drops fetch_ready on the next edge, and fetch_ready rises again WORDS+1 edges after the flush edge. During reset, fetch_valid and mem_req are low.
- R2: A fetch is cacheable when address bits [31:24] equal 0x00 or 0x80. A cacheable fetch whose slot (index = address bits [11:2]) holds the tag {address[23:2],2'b00} is a hit. It returns the stored word with fetch_valid high on the clock after acceptance, and it issues no memory read. Address bits [1:0] are ignored.
- R3: The tag covers only address bits [23:0]. A word filled through one window is a hit through the other window.
- R4: A cacheable miss issues exactly four memory reads, in the order base, base+4, base+8 and base+12, where base is the address with bits [3:0] cleared. Each mem_req holds its address until mem_valid is seen.
- R5: On a miss, fetch_ready is low from acceptance until the answer. The requested word is returned with fetch_valid on the clock after the fourth read completes.
- R6: A non-cacheable fetch issues exactly one read at the address with bits [1:0] cleared and returns that data. It changes no cache entry, even one that the same low address bits index.
- R7: Once a line is filled, its words are returned unchanged on later hits even after memory changes, until a flush. After the flush the next fetch misses and returns the new memory contents.
- R8: A flush raised during a refill is held until the refill finishes. The requested word is still returned, and the clear walk then runs, so the refilled line misses afterwards.
- R9: A cacheable miss to a slot that holds a different tag replaces that line. The earlier address then misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Request is taken on this edge when high |
| fetch_valid | output | 1 | One-cycle strobe for fetch_data |
| fetch_data | output | 32 | Returned opcode |
| flush | input | 1 | Invalidate the whole cache |
| mem_req | output | 1 | Memory read request, held until mem_valid |
| mem_addr | output | 32 | Memory read word address |
| mem_valid | input | 1 | Memory read data strobe |
| mem_data | input | 32 | Memory read data |

## Verification
A hit answers on the edge after acceptance, so the bench drives a request at a falling edge and expects fetch_valid at the very next falling edge. Misses and bypass reads answer one edge after the last memory response. The bench's memory model varies its latency, so the bench waits for the strobe and then compares both the data and the number of reads counted during the fetch. The clear walk is timed by counting falling edges from reset release or from the flush drive until fetch_ready rises: WORDS edges after reset and WORDS+2 after a flush.

// File: rtl/ifetch_cache.sv
module ifetch_cache #(
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_BYTES  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_req,
  input  logic [31:0] fetch_addr,
  output logic        fetch_ready,
  output logic        fetch_valid,
  output logic [31:0] fetch_data,
  input  logic        flush,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_valid,
  input  logic [31:0] mem_data
);
  localparam int WORDS = CACHE_BYTES / 4;
  localparam int IW    = $clog2(WORDS);
  localparam int LW    = $clog2(LINE_BYTES / 4);
  localparam int TW    = 24;

  typedef enum logic [1:0] {S_WIPE, S_IDLE, S_FILL, S_BYP} st_t;

  st_t            state;
  logic [31:0]    data_mem [WORDS];
  logic [TW-1:0]  tag_mem  [WORDS];
  logic [31:0]    req_addr;
  logic [31:0]    hold_word;
  logic [LW-1:0]  beat;
  logic [IW-1:0]  wipe_idx;
  logic           flush_pend;

  wire [IW-1:0] in_idx    = fetch_addr[IW+1:2];
  wire [TW-1:0] in_tag    = {fetch_addr[TW-1:2], 2'b00};
  wire          cacheable = (fetch_addr[31:24] == 8'h00) || (fetch_addr[31:24] == 8'h80);
  wire          hit       = cacheable && (tag_mem[in_idx] == in_tag);
  wire          take      = fetch_req && fetch_ready;

  wire [31:0]   line_base = {req_addr[31:LW+2], {(LW+2){1'b0}}};
  wire [IW-1:0] fill_idx  = {req_addr[IW+1:LW+2], beat};
  wire          last_beat = (beat == {LW{1'b1}});
  wire          want_beat = (beat == req_addr[LW+1:2]);

  assign fetch_ready = (state == S_IDLE) && !flush_pend;
  assign mem_req     = (state == S_FILL) || (state == S_BYP);
  assign mem_addr    = (state == S_FILL) ? (line_base | 32'({beat, 2'b00}))
                                         : {req_addr[31:2], 2'b00};

  always_ff @(posedge clk) begin
    if (state == S_WIPE) begin
      data_mem[wipe_idx] <= '1;
      tag_mem[wipe_idx]  <= '1;
    end else if (state == S_FILL && mem_valid) begin
      data_mem[fill_idx] <= mem_data;
      tag_mem[fill_idx]  <= mem_addr[TW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_WIPE;
      wipe_idx    <= '0;
      beat        <= '0;
      flush_pend  <= 1'b0;
      fetch_valid <= 1'b0;
      fetch_data  <= '0;
      req_addr    <= '0;
      hold_word   <= '0;
    end else begin
      fetch_valid <= 1'b0;
      if (flush) flush_pend <= 1'b1;
      case (state)
        S_WIPE: begin
          wipe_idx <= wipe_idx + 1'b1;
          if (wipe_idx == IW'(WORDS - 1)) state <= S_IDLE;
        end
        S_IDLE: begin
          if (flush_pend) begin
            state      <= S_WIPE;
            wipe_idx   <= '0;
            flush_pend <= flush;
          end else if (take) begin
            req_addr <= fetch_addr;
            if (hit) begin
              fetch_valid <= 1'b1;
              fetch_data  <= data_mem[in_idx];
            end else if (cacheable) begin
              state <= S_FILL;
              beat  <= '0;
            end else begin
              state <= S_BYP;
            end
          end
        end
        S_FILL: begin
          if (mem_valid) begin
            beat <= beat + 1'b1;
            if (want_beat) hold_word <= mem_data;
            if (last_beat) begin
              fetch_valid <= 1'b1;
              fetch_data  <= want_beat ? mem_data : hold_word;
              state       <= S_IDLE;
            end
          end
        end
        S_BYP: begin
          if (mem_valid) begin
            fetch_valid <= 1'b1;
            fetch_data  <= mem_data;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ifetch_cache_chk.sv
module ifetch_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_req,
  input logic        fetch_ready,
  input logic        fetch_valid,
  input logic        mem_req,
  input logic        mem_valid,
  input logic [31:0] mem_addr
);
  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  // R4
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R2
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> !mem_req);

  // R5
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_ready |=> fetch_valid || !fetch_ready);

  // R5
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !mem_req);
endmodule

bind ifetch_cache ifetch_cache_chk u_chk (.*);

// File: tb/sim_ifetch_cache.sv
module sim_ifetch_cache;
  localparam int WORDS = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_ready, fetch_valid;
  logic [31:0] fetch_data;
  logic        flush = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_data = '0;

  int vectors = 0;
  int errors  = 0;
  int gen     = 0;
  int mem_reads = 0;
  int wait_cnt  = 0;
  logic [31:0] rd_log [16];

  always #5 clk = ~clk;

  ifetch_cache u0 (.*);

  function automatic logic [31:0] model(input logic [31:0] a, input int g);
    return (a * 32'h9E37_79B1) ^ (32'(g) * 32'h0100_0193) ^ 32'h5A5A_0000;
  endfunction

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_valid = 1'b1;
        mem_data  = model(mem_addr, gen);
        rd_log[mem_reads % 16] = mem_addr;
        mem_reads++;
        wait_cnt = mem_reads % 3;
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, output logic [31:0] d,
                          output int lat, output int reads, output int r0);
    while (!fetch_ready) @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    r0 = mem_reads;
    @(negedge clk);
    fetch_req = 1'b0;
    lat = 1;
    while (!fetch_valid) begin
      @(negedge clk);
      lat++;
    end
    d = fetch_data;
    reads = mem_reads - r0;
  endtask

  task automatic count_to_ready(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fetch_ready && n < 5000);
  endtask

  task automatic pulse_flush;
    while (!fetch_ready) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lat, reads, r0, n;

    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(fetch_valid), 32'd0);
    chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    count_to_ready(n);
    chk("R1 reset walk length", 32'(n), 32'(WORDS));

    // r2_ r4_ r5_ sweep over every word through the 0x80 window
    for (int i = 0; i < WORDS; i++) begin
      logic [31:0] a;
      a = 32'h8000_0000 + 32'(i * 4);
      do_fetch(a, d, lat, reads, r0);
      chk("R2 sweep data", d, model(a, gen));
      chk("R4 sweep reads", 32'(reads), (i % 4 == 0) ? 32'd4 : 32'd0);
      if (i % 4 != 0) chk("R2 hit latency", 32'(lat), 32'd1);
    end

    // r3_ alias window hits with data filled through 0x80
    for (int i = 0; i < WORDS; i += 3) begin
      do_fetch(32'(i * 4), d, lat, reads, r0);
      chk("R3 alias data", d, model(32'h8000_0000 + 32'(i * 4), gen));
      chk("R3 alias reads", 32'(reads), 32'd0);
    end

    do_fetch(32'h8000_0103, d, lat, reads, r0);
    chk("R2 low bits ignored", d, model(32'h8000_0100, gen));
    chk("R2 low bits reads", 32'(reads), 32'd0);

    // R9 conflict, with R4 ordering
    do_fetch(32'h8000_2238, d, lat, reads, r0);
    chk("R9 conflict data", d, model(32'h8000_2238, gen));
    chk("R9 conflict reads", 32'(reads), 32'd4);
    for (int k = 0; k < 4; k++)
      chk("R4 read order", rd_log[(r0 + k) % 16], 32'h8000_2230 + 32'(4 * k));
    do_fetch(32'h8000_0238, d, lat, reads, r0);
    chk("R9 evicted refetch reads", 32'(reads), 32'd4);
    chk("R9 evicted refetch data", d, model(32'h8000_0238, gen));

    // R6 bypass
    do_fetch(32'hBFC0_023A, d, lat, reads, r0);
    chk("R6 bypass reads", 32'(reads), 32'd1);
    chk("R6 bypass addr", rd_log[r0 % 16], 32'hBFC0_0238);
    chk("R6 bypass data", d, model(32'hBFC0_0238, gen));
    do_fetch(32'h1F00_0238, d, lat, reads, r0);
    chk("R6 bypass repeat reads", 32'(reads), 32'd1);
    do_fetch(32'h8000_0238, d, lat, reads, r0);
    chk("R6 cache untouched reads", 32'(reads), 32'd0);
    chk("R6 cache untouched data", d, model(32'h8000_0238, gen));

    // R7 stale data until flush
    gen = 1;
    do_fetch(32'h8000_0100, d, lat, reads, r0);
    chk("R7 stale data", d, model(32'h8000_0100, 0));
    chk("R7 stale reads", 32'(reads), 32'd0);
    do_fetch(32'h1F00_0100, d, lat, reads, r0);
    chk("R7 bypass sees new", d, model(32'h1F00_0100, 1));
    pulse_flush();
    count_to_ready(n);
    chk("R1 flush walk length", 32'(n + 1), 32'(WORDS + 2));
    do_fetch(32'h8000_0100, d, lat, reads, r0);
    chk("R7 after flush reads", 32'(reads), 32'd4);
    chk("R7 after flush data", d, model(32'h8000_0100, 1));

    // R8 flush during refill
    while (!fetch_ready) @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = 32'h8000_0548;
    r0 = mem_reads;
    @(negedge clk);
    fetch_req = 1'b0;
    chk("R5 ready low in refill", 32'(fetch_ready), 32'd0);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    while (!fetch_valid) @(negedge clk);
    chk("R8 deferred data", fetch_data, model(32'h8000_0548, 1));
    chk("R8 deferred reads", 32'(mem_reads - r0), 32'd4);
    count_to_ready(n);
    chk("R8 walk after refill", 32'(n >= WORDS), 32'd1);
    do_fetch(32'h8000_0548, d, lat, reads, r0);
    chk("R8 line cleared reads", 32'(reads), 32'd4);
    do_fetch(32'h8000_054C, d, lat, reads, r0);
    chk("R2 hit after refill", 32'(reads), 32'd0);
    chk("R2 hit after refill latency", 32'(lat), 32'd1);

    report();
    $finish;
  end
endmodule